// File: doc/BRIEF.md
# Flash Command-Sequence Decoder

This block is the command register of one flash bank. It watches the write cycles presented to the bank; each cycle carries an address and a data word. It recognises command sequences that open with a pair of unlock writes. When a sequence completes, the block issues a one-cycle request pulse for a program, a chip erase, a sector erase, an erase suspend or an erase resume. With each pulse it presents the address and data of the cycle that finished the command. It also holds the bank's mode flags: identification (autoselect) mode, the shortened unlock-bypass command mode, erase-suspended state, the sticky power-saving output enable, and the 2-bit wait-state selection.

The embedded program and erase engines sit outside this block. They raise `busy` while an operation launched here is running. The block remembers which kind of operation it last launched, so it can decide which writes to honour while `busy` is high. Any cycle that breaks a sequence drops the bank back to plain read. Only the sequence is lost; the persistent mode flags survive.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all pulses are low, the autoselect, bypass, suspend and power-saving flags are 0, and `waitSel` is 3 (seven total cycles).
- R2: The cycles (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (A, D) raise `progPulse` for one cycle after the fourth write, with `opAddr`=A and `opData`=D.
- R3: Unlock, (0x555, 0x80), unlock, then (0x555, 0x10) raises `chipErasePulse`. Ending instead with (S, 0x30) at any address raises `sectorErasePulse`, with `opAddr`=S.
- R4: Any cycle whose address or data does not fit the sequence returns the decoder to read, so the following cycles must restart from the first unlock. Only address bits 10:0 and data bits 7:0 are compared; higher bits are ignored.
- R5: Unlock followed by (0x555, 0x20) sets `bypassMode`. In bypass mode, data 0xA0 followed by (A, D) is a program. Data 0x80 followed by 0x10 is a chip erase, and 0x80 followed by 0x30 is a sector erase at the second cycle's address. Other cycles leave bypass mode set.
- R6: In bypass mode, data 0x90 followed by data 0x00 clears `bypassMode`. Afterwards a two-cycle program is no longer accepted.
- R7: Unlock followed by (0x555, 0x90) sets `autoselMode`. The flag is cleared by the next accepted write, such as 0xF0 or any invalid cycle, unless that write is one of the two unlock cycles opening a sequence.
- R8: Unlock followed by data 0xC0 at low address 0x555 loads `waitSel` from address bits 13:12. No other cycle changes `waitSel`.
- R9: Unlock followed by (0x555, 0x70) sets `psEnable`. No write clears it; only reset does.
- R10: While `busy` is high, every write except an erase suspend is ignored, including 0xF0. No program, erase or resume pulse follows a write made while busy.
- R11: Data 0xB0 while busy with a sector erase raises `suspendPulse` and sets `suspendMode`. 0xB0 during a program or chip erase is ignored. Data 0x30 while suspended and idle raises `resumePulse` and clears `suspendMode`. 0x30 outside suspend is an invalid cycle.
- R12: While suspended, a program sequence is accepted, but an erase sequence is rejected at its 0x80 cycle. After a resume, the operation in progress is again a sector erase, so it can be suspended again.
- R13: At most one pulse is high in any cycle. A pulse appears only in the cycle after an accepted write and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrValid | input | 1 | A write cycle is present this clock |
| wrAddr | input | 21 | Write cycle address |
| wrData | input | 16 | Write cycle data |
| busy | input | 1 | An embedded program or erase is running |
| progPulse | output | 1 | Program request |
| chipErasePulse | output | 1 | Chip erase request |
| sectorErasePulse | output | 1 | Sector erase request |
| suspendPulse | output | 1 | Erase suspend request |
| resumePulse | output | 1 | Erase resume request |
| opAddr | output | 21 | Address captured with the last pulse |
| opData | output | 16 | Data captured with the last pulse |
| autoselMode | output | 1 | Identification mode active |
| bypassMode | output | 1 | Shortened command mode active |
| suspendMode | output | 1 | Sector erase suspended |
| psEnable | output | 1 | Power-saving output encoding enabled |
| waitSel | output | 2 | Wait-state setting, 0..3 for 4..7 total cycles |

## Verification
The assertions assume that `rstN` is low from time zero. They also assume that `busy` stands only for operations this decoder launched: it rises after a program or erase pulse and falls after a suspend or when the work ends. The suspend and busy-gating properties are meaningful only under that assumption. The stimulus raises `busy` only right after a launch pulse and lowers it before any further command sequence. It presents each write as a single-cycle strobe with idle cycles between writes, and it deliberately sets upper address and data bits to exercise the don't-care rule.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    SEQ_IDLE, SEQ_UNL1, SEQ_UNL2, SEQ_PADDR,
    SEQ_ERA1, SEQ_ERA2, SEQ_ERA3, SEQ_BERA, SEQ_BEXIT
  } seqState_t;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_CHIP, OP_SECT} opKind_t;

  typedef struct packed {
    logic accept;
    logic doProg;
    logic doChip;
    logic doSect;
    logic doSusp;
    logic doResume;
    logic setBypass;
    logic clrBypass;
    logic setAutosel;
    logic keepAutosel;
    logic setWait;
    logic setPs;
  } cmdStrobe_t;

  localparam logic [7:0] CODE_UNLOCK1  = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK2  = 8'h55;
  localparam logic [7:0] CODE_PROG     = 8'hA0;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECT     = 8'h30;
  localparam logic [7:0] CODE_RESUME   = 8'h30;
  localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
  localparam logic [7:0] CODE_BYPASS   = 8'h20;
  localparam logic [7:0] CODE_AUTOSEL  = 8'h90;
  localparam logic [7:0] CODE_BYP_EXIT = 8'h00;
  localparam logic [7:0] CODE_WAIT     = 8'hC0;
  localparam logic [7:0] CODE_PSAVE    = 8'h70;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int CMP_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [CMP_AW-1:0] cmpAddr,
  input  logic [7:0]        cmpData,
  input  logic              busy,
  input  opKind_t           activeOp,
  input  logic              suspendMode,
  input  logic              bypassMode,
  output cmdStrobe_t        strb
);

  localparam logic [CMP_AW-1:0] ADDR_FIRST  = CMP_AW'(11'h555);
  localparam logic [CMP_AW-1:0] ADDR_SECOND = CMP_AW'(11'h2AA);

  seqState_t state, nxt;
  logic atFirst, firstUnlock, secondUnlock;

  assign atFirst      = (cmpAddr == ADDR_FIRST);
  assign firstUnlock  = atFirst && (cmpData == CODE_UNLOCK1);
  assign secondUnlock = (cmpAddr == ADDR_SECOND) && (cmpData == CODE_UNLOCK2);

  always_comb begin
    strb = '0;
    nxt  = state;
    if (wrValid) begin
      if (busy) begin
        strb.doSusp = (cmpData == CODE_SUSPEND) && (activeOp == OP_SECT) && !suspendMode;
      end else begin
        strb.accept = 1'b1;
        nxt = SEQ_IDLE;
        case (state)
          SEQ_IDLE: begin
            if (suspendMode && cmpData == CODE_RESUME) begin
              strb.doResume = 1'b1;
            end else if (bypassMode) begin
              if (cmpData == CODE_PROG) nxt = SEQ_PADDR;
              else if (cmpData == CODE_ERASE && !suspendMode) nxt = SEQ_BERA;
              else if (cmpData == CODE_AUTOSEL) nxt = SEQ_BEXIT;
            end else if (firstUnlock) begin
              nxt = SEQ_UNL1;
              strb.keepAutosel = 1'b1;
            end
          end
          SEQ_UNL1: begin
            if (secondUnlock) begin
              nxt = SEQ_UNL2;
              strb.keepAutosel = 1'b1;
            end
          end
          SEQ_UNL2: begin
            if (atFirst) begin
              case (cmpData)
                CODE_PROG:    nxt = SEQ_PADDR;
                CODE_ERASE:   if (!suspendMode) nxt = SEQ_ERA1;
                CODE_BYPASS:  strb.setBypass = 1'b1;
                CODE_AUTOSEL: strb.setAutosel = 1'b1;
                CODE_WAIT:    strb.setWait = 1'b1;
                CODE_PSAVE:   strb.setPs = 1'b1;
                default:      ;
              endcase
            end
          end
          SEQ_PADDR: strb.doProg = 1'b1;
          SEQ_ERA1:  if (firstUnlock) nxt = SEQ_ERA2;
          SEQ_ERA2:  if (secondUnlock) nxt = SEQ_ERA3;
          SEQ_ERA3: begin
            if (atFirst && cmpData == CODE_CHIP) strb.doChip = 1'b1;
            else if (cmpData == CODE_SECT) strb.doSect = 1'b1;
          end
          SEQ_BERA: begin
            if (cmpData == CODE_CHIP) strb.doChip = 1'b1;
            else if (cmpData == CODE_SECT) strb.doSect = 1'b1;
          end
          SEQ_BEXIT: if (cmpData == CODE_BYP_EXIT) strb.clrBypass = 1'b1;
          default: nxt = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nxt;
  end

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int WAIT_W   = 2,
  parameter int WAIT_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              progPulse,
  output logic              chipErasePulse,
  output logic              sectorErasePulse,
  output logic              suspendPulse,
  output logic              resumePulse,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              autoselMode,
  output logic              bypassMode,
  output logic              suspendMode,
  output logic              psEnable,
  output logic [WAIT_W-1:0] waitSel,
  output opKind_t           activeOp
);

  logic anyOp;
  assign anyOp = strb.doProg | strb.doChip | strb.doSect | strb.doSusp | strb.doResume;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progPulse        <= 1'b0;
      chipErasePulse   <= 1'b0;
      sectorErasePulse <= 1'b0;
      suspendPulse     <= 1'b0;
      resumePulse      <= 1'b0;
      opAddr           <= '0;
      opData           <= '0;
      autoselMode      <= 1'b0;
      bypassMode       <= 1'b0;
      suspendMode      <= 1'b0;
      psEnable         <= 1'b0;
      waitSel          <= '1;
      activeOp         <= OP_NONE;
    end else begin
      progPulse        <= strb.doProg;
      chipErasePulse   <= strb.doChip;
      sectorErasePulse <= strb.doSect;
      suspendPulse     <= strb.doSusp;
      resumePulse      <= strb.doResume;
      if (anyOp) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
      if (strb.doProg)                      activeOp <= OP_PROG;
      else if (strb.doChip)                 activeOp <= OP_CHIP;
      else if (strb.doSect | strb.doResume) activeOp <= OP_SECT;
      if (strb.doSusp)        suspendMode <= 1'b1;
      else if (strb.doResume) suspendMode <= 1'b0;
      if (strb.setBypass)      bypassMode <= 1'b1;
      else if (strb.clrBypass) bypassMode <= 1'b0;
      if (strb.accept) autoselMode <= strb.setAutosel | (autoselMode & strb.keepAutosel);
      if (strb.setWait) waitSel <= wrAddr[WAIT_LSB +: WAIT_W];
      if (strb.setPs)   psEnable <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int CMP_AW   = 11,
  parameter int WAIT_W   = 2,
  parameter int WAIT_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  output logic              progPulse,
  output logic              chipErasePulse,
  output logic              sectorErasePulse,
  output logic              suspendPulse,
  output logic              resumePulse,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              autoselMode,
  output logic              bypassMode,
  output logic              suspendMode,
  output logic              psEnable,
  output logic [WAIT_W-1:0] waitSel
);

  localparam int CODE_W = 8;

  cmdStrobe_t strb;
  opKind_t    activeOp;

  flash_cmd_ctrl #(.CMP_AW(CMP_AW)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrValid     (wrValid),
    .cmpAddr     (wrAddr[CMP_AW-1:0]),
    .cmpData     (wrData[CODE_W-1:0]),
    .busy        (busy),
    .activeOp    (activeOp),
    .suspendMode (suspendMode),
    .bypassMode  (bypassMode),
    .strb        (strb)
  );

  flash_cmd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .WAIT_LSB(WAIT_LSB)
  ) dp_i (
    .clk              (clk),
    .rstN             (rstN),
    .strb             (strb),
    .wrAddr           (wrAddr),
    .wrData           (wrData),
    .progPulse        (progPulse),
    .chipErasePulse   (chipErasePulse),
    .sectorErasePulse (sectorErasePulse),
    .suspendPulse     (suspendPulse),
    .resumePulse      (resumePulse),
    .opAddr           (opAddr),
    .opData           (opData),
    .autoselMode      (autoselMode),
    .bypassMode       (bypassMode),
    .suspendMode      (suspendMode),
    .psEnable         (psEnable),
    .waitSel          (waitSel),
    .activeOp         (activeOp)
  );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int WAIT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              busy,
  input logic              progPulse,
  input logic              chipErasePulse,
  input logic              sectorErasePulse,
  input logic              suspendPulse,
  input logic              resumePulse,
  input logic              bypassMode,
  input logic              suspendMode,
  input logic              psEnable,
  input logic [WAIT_W-1:0] waitSel
);

  logic [4:0] pulses;
  assign pulses = {progPulse, chipErasePulse, sectorErasePulse, suspendPulse, resumePulse};

  // R13
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulses));

  // R13
  pulse_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|pulses) |-> $past(wrValid));

  // R2
  prog_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    progPulse |=> !progPulse);

  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progPulse | chipErasePulse | sectorErasePulse | resumePulse) |-> !$past(busy));

  // R9
  ps_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(psEnable) |-> psEnable);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrValid) |-> $stable(waitSel));

  // R5
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrValid) |-> $stable(bypassMode));

  // R11
  susp_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspendPulse |-> suspendMode);

  // R11
  resume_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> !suspendMode);

endmodule

bind flash_cmd_decoder flash_cmd_checker #(.WAIT_W(WAIT_W)) chk_i (
  .clk              (clk),
  .rstN             (rstN),
  .wrValid          (wrValid),
  .busy             (busy),
  .progPulse        (progPulse),
  .chipErasePulse   (chipErasePulse),
  .sectorErasePulse (sectorErasePulse),
  .suspendPulse     (suspendPulse),
  .resumePulse      (resumePulse),
  .bypassMode       (bypassMode),
  .suspendMode      (suspendMode),
  .psEnable         (psEnable),
  .waitSel          (waitSel)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [20:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        busy = 1'b0;
  logic        progPulse, chipErasePulse, sectorErasePulse, suspendPulse, resumePulse;
  logic [20:0] opAddr;
  logic [15:0] opData;
  logic        autoselMode, bypassMode, suspendMode, psEnable;
  logic [1:0]  waitSel;

  int nChecks = 0;
  int nFail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .progPulse(progPulse), .chipErasePulse(chipErasePulse),
    .sectorErasePulse(sectorErasePulse), .suspendPulse(suspendPulse),
    .resumePulse(resumePulse), .opAddr(opAddr), .opData(opData),
    .autoselMode(autoselMode), .bypassMode(bypassMode), .suspendMode(suspendMode),
    .psEnable(psEnable), .waitSel(waitSel)
  );

  // pulse vector order: prog, chip, sector, suspend, resume
  localparam logic [4:0] P_NONE = 5'b00000, P_PROG = 5'b10000, P_CHIP = 5'b01000,
                         P_SECT = 5'b00100, P_SUSP = 5'b00010, P_RES = 5'b00001;
  wire [4:0] pv = {progPulse, chipErasePulse, sectorErasePulse, suspendPulse, resumePulse};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [15:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic unlock();
    wr(21'h555, 16'h00AA);
    wr(21'h2AA, 16'h0055);
  endtask

  task automatic setBusy(input logic b);
    @(negedge clk);
    busy = b;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 pulses", 32'(pv), 32'(P_NONE));
    chk("R1 flags", {28'd0, autoselMode, bypassMode, suspendMode, psEnable}, 32'd0);
    chk("R1 waitSel", 32'(waitSel), 32'd3);
  endtask

  task automatic t_program();
    unlock();
    wr(21'h555, 16'h00A0);
    chk("R2 no early pulse", 32'(pv), 32'(P_NONE));
    wr(21'h1ABCD, 16'h5A3C);
    chk("R2 R13 prog pulse", 32'(pv), 32'(P_PROG));
    chk("R2 addr", 32'(opAddr), 32'h1ABCD);
    chk("R2 data", 32'(opData), 32'h5A3C);
    @(negedge clk);
    chk("R13 single cycle", 32'(pv), 32'(P_NONE));
  endtask

  task automatic t_erase();
    unlock(); wr(21'h555, 16'h0080); unlock();
    wr(21'h555, 16'h0010);
    chk("R3 chip erase", 32'(pv), 32'(P_CHIP));
    unlock(); wr(21'h555, 16'h0080); unlock();
    wr(21'h12345, 16'h0030);
    chk("R3 sector erase", 32'(pv), 32'(P_SECT));
    chk("R3 sector addr", 32'(opAddr), 32'h12345);
  endtask

  task automatic t_abort();
    wr(21'h555, 16'h00AA);
    wr(21'h2AB, 16'h0055);
    wr(21'h555, 16'h00A0);
    wr(21'h00100, 16'h1234);
    chk("R4 bad addr aborts", 32'(pv), 32'(P_NONE));
    wr(21'h555, 16'h00AA);
    wr(21'h2AA, 16'h0056);
    wr(21'h555, 16'h00A0);
    wr(21'h00100, 16'h1234);
    chk("R4 bad data aborts", 32'(pv), 32'(P_NONE));
    wr(21'h1F0555, 16'hFFAA);
    wr(21'h000AAA, 16'h3355);
    wr(21'h007555, 16'h12A0);
    wr(21'h00222, 16'hBEEF);
    chk("R4 upper bits ignored", 32'(pv), 32'(P_PROG));
  endtask

  task automatic t_bypass();
    unlock(); wr(21'h555, 16'h0020);
    chk("R5 bypass set", 32'(bypassMode), 32'd1);
    wr(21'h0, 16'h00A0);
    wr(21'h02222, 16'h00FF);
    chk("R5 bypass program", 32'(pv), 32'(P_PROG));
    chk("R5 bypass prog data", 32'(opData), 32'h00FF);
    wr(21'h0, 16'h0080);
    wr(21'h98000, 16'h0030);
    chk("R5 bypass sector", 32'(pv), 32'(P_SECT));
    chk("R5 bypass sector addr", 32'(opAddr), 32'h98000);
    wr(21'h0, 16'h0080);
    wr(21'h0, 16'h0010);
    chk("R5 bypass chip", 32'(pv), 32'(P_CHIP));
    wr(21'h555, 16'h00AA);
    chk("R5 invalid keeps bypass", 32'(bypassMode), 32'd1);
  endtask

  task automatic t_bypassExit();
    wr(21'h0, 16'h0090);
    wr(21'h0, 16'h0055);
    chk("R6 wrong second exit cycle", 32'(bypassMode), 32'd1);
    wr(21'h0, 16'h0090);
    wr(21'h0, 16'h0000);
    chk("R6 bypass cleared", 32'(bypassMode), 32'd0);
    wr(21'h0, 16'h00A0);
    wr(21'h00444, 16'h1111);
    chk("R6 short program refused", 32'(pv), 32'(P_NONE));
  endtask

  task automatic t_autosel();
    unlock(); wr(21'h555, 16'h0090);
    chk("R7 autoselect set", 32'(autoselMode), 32'd1);
    wr(21'h0, 16'h00F0);
    chk("R7 reset cmd clears", 32'(autoselMode), 32'd0);
    unlock(); wr(21'h555, 16'h0090);
    wr(21'h555, 16'h00AA);
    chk("R7 unlock keeps", 32'(autoselMode), 32'd1);
    wr(21'h123, 16'h0045);
    chk("R7 invalid clears", 32'(autoselMode), 32'd0);
  endtask

  task automatic t_wait();
    unlock(); wr(21'h2555, 16'h00C0);
    chk("R8 wait=2", 32'(waitSel), 32'd2);
    unlock(); wr(21'h0, 16'h0020);
    wr(21'h0, 16'h0090); wr(21'h0, 16'h0000);
    chk("R8 other cmds keep wait", 32'(waitSel), 32'd2);
    unlock(); wr(21'h0555, 16'h00C0);
    chk("R8 wait=0", 32'(waitSel), 32'd0);
  endtask

  task automatic t_busy();
    unlock(); wr(21'h555, 16'h00A0); wr(21'h00010, 16'h0001);
    chk("R10 launch", 32'(pv), 32'(P_PROG));
    setBusy(1'b1);
    wr(21'h0, 16'h00F0);
    unlock(); wr(21'h555, 16'h00A0); wr(21'h00020, 16'h0002);
    chk("R10 program ignored while busy", 32'(pv), 32'(P_NONE));
    wr(21'h0, 16'h00B0);
    chk("R11 suspend ignored in program", 32'(pv), 32'(P_NONE));
    setBusy(1'b0);
    unlock(); wr(21'h555, 16'h0080); unlock(); wr(21'h555, 16'h0010);
    chk("R10 chip launch", 32'(pv), 32'(P_CHIP));
    setBusy(1'b1);
    wr(21'h0, 16'h00B0);
    chk("R11 suspend ignored in chip erase", 32'(pv), 32'(P_NONE));
    chk("R11 no suspend flag", 32'(suspendMode), 32'd0);
    setBusy(1'b0);
  endtask

  task automatic t_suspend();
    unlock(); wr(21'h555, 16'h0080); unlock(); wr(21'h40000, 16'h0030);
    chk("R11 sector launch", 32'(pv), 32'(P_SECT));
    setBusy(1'b1);
    wr(21'h0, 16'h00B0);
    chk("R11 suspend pulse", 32'(pv), 32'(P_SUSP));
    chk("R11 suspend flag", 32'(suspendMode), 32'd1);
    setBusy(1'b0);
    unlock(); wr(21'h555, 16'h0080); unlock(); wr(21'h48000, 16'h0030);
    chk("R12 erase refused in suspend", 32'(pv), 32'(P_NONE));
    unlock(); wr(21'h555, 16'h00A0); wr(21'h00777, 16'h7777);
    chk("R12 program in suspend", 32'(pv), 32'(P_PROG));
    setBusy(1'b1); setBusy(1'b0);
    wr(21'h0, 16'h0030);
    chk("R11 resume pulse", 32'(pv), 32'(P_RES));
    chk("R11 resume clears flag", 32'(suspendMode), 32'd0);
    setBusy(1'b1);
    wr(21'h0, 16'h00B0);
    chk("R12 suspend again after resume", 32'(pv), 32'(P_SUSP));
    setBusy(1'b0);
    wr(21'h0, 16'h0030);
    chk("R11 second resume", 32'(pv), 32'(P_RES));
    wr(21'h0, 16'h0030);
    chk("R11 resume outside suspend", 32'(pv), 32'(P_NONE));
  endtask

  task automatic t_ps();
    unlock(); wr(21'h555, 16'h0070);
    chk("R9 ps set", 32'(psEnable), 32'd1);
    wr(21'h0, 16'h00F0);
    wr(21'h0, 16'h0012);
    chk("R9 ps sticky", 32'(psEnable), 32'd1);
    doReset();
    @(negedge clk);
    chk("R9 ps cleared by reset", 32'(psEnable), 32'd0);
    chk("R1 wait after reset", 32'(waitSel), 32'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_abort();
    t_bypass();
    t_bypassExit();
    t_autosel();
    t_wait();
    t_busy();
    t_suspend();
    t_ps();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule